// File: doc/BRIEF.md
# Modulated fractional baud-rate generator

This block times the bits of one asynchronous serial character. It runs from a
reference clock enable. Each bit period is a whole number of reference ticks:
an integer divisor, plus one extra tick when that bit position's entry in an
8-bit modulation pattern is set. Some bits are stretched by one tick and others
are not. The average divisor is therefore fractional, and the bit edges stay
close to their ideal positions over the whole character instead of drifting.

The generator waits in idle until a start pulse arrives. It then counts bit
positions 0 to 10. Position 0 is the start bit, positions 1 to 8 are data bits
D0 to D7, position 9 is parity and position 10 is the first stop bit. At the
end of every bit it emits a one-cycle strobe. When the stop bit ends it also
flags frame completion and returns to idle. Choosing the reference clock,
shifting the data, computing parity and receiving are done elsewhere.

Top module: `mod_baud_gen`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, `bit_strobe_o` and `frame_done_o` are 0 and `bit_idx_o` is 0.
- R2: Before any start pulse the block is idle. No `ref_en_i` activity produces a strobe, and `bit_idx_o` stays 0.
- R3: Bit j lasts exactly `eff_div + m` cycles in which `ref_en_i` is 1. Here `eff_div` is the effective divisor and `m` is that bit's modulation bit. Cycles with `ref_en_i` at 0 do not advance timing. `ref_en_i` is ignored in the cycle where `start_i` is sampled.
- R4: Bit j uses `mod_i[j mod 8]`. Bit 0 of `mod_i` applies to the start bit and higher bits apply to later positions. Positions 8, 9 and 10 wrap to `mod_i[0]`, `mod_i[1]` and `mod_i[2]`.
- R5: `bit_strobe_o` pulses for one clock, in the cycle after the clock edge that carries the final `ref_en_i` tick of a bit. `bit_idx_o` is 0 after a start and steps to j+1 together with the strobe that ends bit j.
- R6: When bit 10 ends, `frame_done_o` pulses in the same cycle as its strobe. At that point `bit_idx_o` returns to 0, and no further strobe comes until the next start pulse.
- R7: A `divisor_i` value below 3 is treated as 3.
- R8: A start pulse during a frame abandons that frame. Timing restarts from zero at bit 0, and no strobe appears in the cycle after the start.
- R9: With divisor 13 and pattern 0x6B, the tick counts at the end of bits 0 to 10, counted from the start, are 14, 28, 41, 55, 68, 82, 96, 109, 123, 137 and 150.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_en_i | input | 1 | One reference tick per cycle when high |
| divisor_i | input | 16 | Integer bit divisor (values below 3 act as 3) |
| mod_i | input | 8 | Per-position stretch pattern, bit 0 first |
| start_i | input | 1 | Begin a new character |
| bit_strobe_o | output | 1 | One-cycle pulse at each bit boundary |
| bit_idx_o | output | 4 | Bit position now in progress |
| frame_done_o | output | 1 | One-cycle pulse when the stop bit ends |

## Verification
Some internal faults leave the stretch pattern or the bit counter wrong without touching the strobe shape. Those faults appear as a strobe that lands one or more ticks away from the running sum of divisor and pattern bits. That shift shows up by the first bit whose pattern entry is set, so tick counts are compared at every boundary for several divisor, pattern and tick-gap mixes. A wrong position counter shows at once in `bit_idx_o` beside the strobe. A missed return to idle shows as a stray strobe within one bit period after frame completion.

// File: rtl/mbg_pkg.sv
package mbg_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mbg_state_e;
endpackage

// File: rtl/mbg_period_sel.sv
module mbg_period_sel #(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned MOD_W   = 8,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned MIN_DIV = 3
) (
  input  logic [DIV_W-1:0] divisor_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  output logic [DIV_W:0]   period_o
);
  localparam bit MOD_POW2 = (MOD_W & (MOD_W - 1)) == 0;

  logic [IDX_W-1:0] wrap_idx;
  logic             mbit;
  logic [DIV_W-1:0] div_eff;

  generate
    if (MOD_POW2) begin : g_mask
      assign wrap_idx = bit_idx_i & IDX_W'(MOD_W - 1);
    end else begin : g_mod
      assign wrap_idx = IDX_W'(bit_idx_i % IDX_W'(MOD_W));
    end
  endgenerate

  always_comb begin
    mbit = 1'b0;
    for (int k = 0; k < MOD_W; k++) begin
      if (wrap_idx == IDX_W'(k)) mbit = mod_i[k];
    end
  end

  assign div_eff  = (divisor_i < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : divisor_i;
  assign period_o = {1'b0, div_eff} + (DIV_W+1)'(mbit);
endmodule

// File: rtl/mbg_bit_timer.sv
module mbg_bit_timer #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  // >= guards against a period lowered mid-bit
  assign last_o = tick_i && ((cnt_q + CNT_W'(1)) >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/mbg_seq.sv
module mbg_seq
  import mbg_pkg::*;
#(
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned LAST_BIT = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             last_i,
  output logic             run_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             strobe_o,
  output logic             done_o
);
  mbg_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             strobe_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      strobe_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      done_q   <= 1'b0;
      if (start_i) begin
        state_q <= ST_RUN;
        idx_q   <= '0;
      end else if (state_q == ST_RUN && tick_i && last_i) begin
        strobe_q <= 1'b1;
        if (idx_q == IDX_W'(LAST_BIT)) begin
          done_q  <= 1'b1;
          idx_q   <= '0;
          state_q <= ST_IDLE;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  assign run_o    = (state_q == ST_RUN);
  assign idx_o    = idx_q;
  assign strobe_o = strobe_q;
  assign done_o   = done_q;
endmodule

// File: rtl/mod_baud_gen.sv
module mod_baud_gen #(
  parameter  int unsigned DIV_W    = 16,
  parameter  int unsigned MOD_W    = 8,
  parameter  int unsigned LAST_BIT = 10,
  parameter  int unsigned MIN_DIV  = 3,
  localparam int unsigned IDX_W    = $clog2(LAST_BIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_en_i,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic             start_i,
  output logic             bit_strobe_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             frame_done_o
);
  localparam int unsigned CNT_W = DIV_W + 1;

  logic             run;
  logic             tick;
  logic             last;
  logic [CNT_W-1:0] period;
  logic [IDX_W-1:0] idx;

  assign tick = ref_en_i & run & ~start_i;

  mbg_period_sel #(
    .DIV_W  (DIV_W),
    .MOD_W  (MOD_W),
    .IDX_W  (IDX_W),
    .MIN_DIV(MIN_DIV)
  ) u_period (
    .divisor_i(divisor_i),
    .mod_i    (mod_i),
    .bit_idx_i(idx),
    .period_o (period)
  );

  mbg_bit_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_i | ~run),
    .tick_i  (tick),
    .period_i(period),
    .last_o  (last)
  );

  mbg_seq #(
    .IDX_W   (IDX_W),
    .LAST_BIT(LAST_BIT)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .tick_i  (tick),
    .last_i  (last),
    .run_o   (run),
    .idx_o   (idx),
    .strobe_o(bit_strobe_o),
    .done_o  (frame_done_o)
  );

  assign bit_idx_o = idx;
endmodule

// File: rtl/mbg_checker.sv
module mbg_checker #(
  parameter  int unsigned LAST_BIT = 10,
  parameter  int unsigned MIN_DIV  = 3,
  localparam int unsigned IDX_W    = $clog2(LAST_BIT + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ref_en_i,
  input logic             start_i,
  input logic             bit_strobe_o,
  input logic [IDX_W-1:0] bit_idx_o,
  input logic             frame_done_o
);
  localparam int unsigned GAP_W = 18;
  logic [GAP_W-1:0] gap_q;

  // ref ticks since last start or bit boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           gap_q <= '0;
    else if (start_i)      gap_q <= '0;
    else if (bit_strobe_o) gap_q <= GAP_W'(ref_en_i);
    else if (ref_en_i && gap_q != '1) gap_q <= gap_q + GAP_W'(1);
  end

  p_strobe_needs_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_strobe_o |-> ($past(ref_en_i) && !$past(start_i)));

  p_idx_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_idx_o <= IDX_W'(LAST_BIT));

  p_idx_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_strobe_o && !frame_done_o) |-> bit_idx_o == IDX_W'($past(bit_idx_o) + 1'b1));

  p_done_with_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (bit_strobe_o && bit_idx_o == '0));

  p_done_then_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !bit_strobe_o);

  p_min_period_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_strobe_o |-> gap_q >= GAP_W'(MIN_DIV));

  p_start_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (bit_idx_o == '0 && !bit_strobe_o));
endmodule

bind mod_baud_gen mbg_checker #(
  .LAST_BIT(LAST_BIT),
  .MIN_DIV (MIN_DIV)
) u_mbg_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ref_en_i    (ref_en_i),
  .start_i     (start_i),
  .bit_strobe_o(bit_strobe_o),
  .bit_idx_o   (bit_idx_o),
  .frame_done_o(frame_done_o)
);

// File: tb/tb_mod_baud_gen.sv
`timescale 1ns/1ps
module tb_mod_baud_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_en_i = 1'b0;
  logic [15:0] divisor_i = 16'd0;
  logic [7:0]  mod_i = 8'd0;
  logic        start_i = 1'b0;
  logic        bit_strobe_o;
  logic [3:0]  bit_idx_o;
  logic        frame_done_o;

  int checks = 0;
  int errors = 0;
  int cap [11];

  always #2.5 clk_i = ~clk_i;

  mod_baud_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_en_i(ref_en_i), .divisor_i(divisor_i),
    .mod_i(mod_i), .start_i(start_i), .bit_strobe_o(bit_strobe_o),
    .bit_idx_o(bit_idx_o), .frame_done_o(frame_done_o)
  );

  // {gap[1:0], divisor[15:0], pattern[7:0]}
  localparam logic [25:0] VEC [8] = '{
    {2'd0, 16'd13, 8'h6B}, {2'd1, 16'd4, 8'h00}, {2'd0, 16'd4, 8'hFF},
    {2'd2, 16'd5, 8'hA5},  {2'd0, 16'd1, 8'h0F}, {2'd1, 16'd0, 8'h81},
    {2'd0, 16'd2, 8'h3C},  {2'd3, 16'd9, 8'h52}
  };
  localparam int EX_CUM [11] = '{14, 28, 41, 55, 68, 82, 96, 109, 123, 137, 150};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk_i);
    start_i  = 1'b1;
    ref_en_i = 1'b1;  // must be ignored in the start cycle (R3)
    @(negedge clk_i);
    start_i  = 1'b0;
    ref_en_i = 1'b0;
    chk(bit_idx_o == 4'd0 && !bit_strobe_o, "R8 state after start", bit_idx_o, 0);
  endtask

  task automatic run_frame(input int div, input int pat, input int gap);
    int ticks = 0;
    int j = 0;
    int cyc = 0;
    int exp_cum = 0;
    int eff;
    divisor_i = div[15:0];
    mod_i = pat[7:0];
    eff = (div < 3) ? 3 : div;  // R7
    do_start();
    while (j < 11 && cyc < 20000) begin
      logic en;
      en = ((cyc % (gap + 1)) == 0);
      ref_en_i = en;
      @(negedge clk_i);
      cyc++;
      if (en) ticks++;
      if (bit_strobe_o) begin
        exp_cum += eff + ((pat >> (j % 8)) & 1);  // R4 wrap
        cap[j] = ticks;
        chk(ticks == exp_cum, "R3/R4 tick count at boundary", ticks, exp_cum);
        chk(int'(bit_idx_o) == ((j == 10) ? 0 : j + 1), "R5 bit index", bit_idx_o, (j == 10) ? 0 : j + 1);
        chk(frame_done_o == (j == 10), "R6 frame done", frame_done_o, j == 10);
        j++;
      end else if (frame_done_o) begin
        chk(1'b0, "R6 done without strobe", 1, 0);
      end
    end
    chk(j == 11, "R6 boundaries in frame", j, 11);
    ref_en_i = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_i);
      if (bit_strobe_o) chk(1'b0, "R6 strobe after frame end", 1, 0);
    end
    chk(bit_idx_o == 4'd0, "R6 idle index", bit_idx_o, 0);
    ref_en_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!bit_strobe_o && !frame_done_o && bit_idx_o == 0, "R1 in reset", bit_strobe_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!bit_strobe_o && !frame_done_o && bit_idx_o == 0, "R1 after reset", bit_idx_o, 0);

    // R2: free-running ticks with no start
    divisor_i = 16'd3;
    ref_en_i = 1'b1;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk_i);
      if (bit_strobe_o || bit_idx_o != 0) chk(1'b0, "R2 idle activity", bit_idx_o, 0);
    end
    chk(!bit_strobe_o, "R2 idle quiet", bit_strobe_o, 0);
    ref_en_i = 1'b0;

    for (int v = 0; v < 8; v++)
      run_frame(int'(VEC[v][23:8]), int'(VEC[v][7:0]), int'(VEC[v][25:24]));

    // R9: the 2400-baud example, explicit list
    run_frame(13, 8'h6B, 0);
    for (int b = 0; b < 11; b++)
      chk(cap[b] == EX_CUM[b], "R9 example boundary", cap[b], EX_CUM[b]);

    // R8: abandon a frame part way, then a full frame must time from zero
    divisor_i = 16'd6;
    mod_i = 8'hFF;
    do_start();
    ref_en_i = 1'b1;
    repeat (20) @(negedge clk_i);
    chk(bit_idx_o == 4'd2, "R8 mid-frame position", bit_idx_o, 2);
    run_frame(6, 8'hFF, 0);

    // R7: divisor 2 behaves as 3
    run_frame(2, 8'h00, 0);
    chk(cap[10] == 33, "R7 clamped frame length", cap[10], 33);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule